// File: doc/BRIEF.md
# Flit Receive-Path Selector and NOP Hint Scheduler

This block chooses, for a 256-byte flit link with a low-latency option, whether received data takes the fast route or the error-correcting route. Every 128-byte half-flit carries its own CRC, and the block sees the result of that check as a status input. While the block is in the fast mode, a half whose CRC passes is released to the upper layer in the same cycle. A half that fails moves the receiver onto the slower corrected route. The receiver stays on that route until an idle bubble arrives in the incoming stream. A bubble is a skip ordered set or a NOP flit. When the receiver falls back to the corrected route, it also tells its own transmitter to send a NOP insertion hint to the link partner.

On the transmit side, the block takes hints from the partner and inserts one NOP flit, or two back-to-back NOP flits, into the outgoing stream. Each NOP goes into the next flit slot. Payload is held off with ready low while NOPs are owed, and no payload flit is dropped or reordered. A hint that arrives while NOPs are still owed sets the owed count to the larger of the old and new values; the two are never summed. The CRC and FEC arithmetic, lane striping and the link layer lie outside the block and appear only as status inputs.

Top module: `flit_path_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `path_fec` is 0 (fast mode), `hint_tx_vld` is 0, `hint_tx_code` is 00, `tx_out_vld` is 0, `tx_out_nop` is 0, `tx_out_data` is 0, and no NOPs are owed.
- R2: When `path_fec` is 0 and a half arrives (`rx_half_vld`=1) with `rx_crc_ok`=0, `path_fec` is 1 from the next cycle on.
- R3: `rx_fast_rel` is 1 in the same cycle exactly when `rx_half_vld`=1, `rx_crc_ok`=1 and `path_fec`=0. `rx_fec_rel` is 1 for every other valid half, so any half received while `path_fec`=1 is routed to the corrected path.
- R4: While `path_fec` is 1, it returns to 0 on the cycle after a cycle with `rx_bubble`=1 and no failing half. In any other case it stays 1. A bubble while `path_fec` is 0 has no effect.
- R5: On the cycle after the entry into the corrected mode, `hint_tx_vld` is 1 for exactly one cycle, with `hint_tx_code` equal to parameter `HINT_REQ`. CRC failures while `path_fec` is already 1 issue no hint. When `hint_tx_vld` is 0, `hint_tx_code` is 00.
- R6: A partner hint (`hint_rx_vld`=1) with code 01 requests one NOP, and code 10 requests two NOPs. Codes 00 and 11 request nothing.
- R7: On each cycle with `tx_slot`=1 and a non-zero owed count, the next cycle shows `tx_out_vld`=1, `tx_out_nop`=1 and `tx_out_data`=0, and the owed count drops by one. A hint counts for slots from the cycle after it arrives.
- R8: `tx_pl_rdy` equals `tx_slot` while no NOP is owed and is 0 otherwise. An accepted payload (`tx_pl_vld`=1 and `tx_pl_rdy`=1) appears on the next cycle with `tx_out_vld`=1, `tx_out_nop`=0 and its data unchanged, in the order accepted.
- R9: A hint that arrives while NOPs are owed sets the owed count to the larger of the remaining count (after any NOP sent that cycle) and the requested count.
- R10: With `tx_slot`=0, the next cycle has `tx_out_vld`=0 and `tx_out_data`=0, and the owed count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_half_vld | input | 1 | A received 128-byte half-flit is present |
| rx_crc_ok | input | 1 | CRC result for that half (1 = good) |
| rx_bubble | input | 1 | Incoming skip ordered set or NOP flit seen |
| rx_fast_rel | output | 1 | Half released on the low-latency route |
| rx_fec_rel | output | 1 | Half sent through the correcting route |
| path_fec | output | 1 | Registered mode: 0 fast, 1 corrected |
| hint_tx_vld | output | 1 | Ask own transmitter to send a hint |
| hint_tx_code | output | 2 | Hint code to send |
| hint_rx_vld | input | 1 | Hint received from partner |
| hint_rx_code | input | 2 | Received hint code |
| tx_slot | input | 1 | A transmit flit slot starts this cycle |
| tx_pl_vld | input | 1 | Payload flit offered |
| tx_pl_data | input | DATA_W | Payload flit tag/data |
| tx_pl_rdy | output | 1 | Payload accepted this cycle |
| tx_out_vld | output | 1 | Registered outgoing flit present |
| tx_out_nop | output | 1 | Outgoing flit is a NOP |
| tx_out_data | output | DATA_W | Outgoing payload data (0 for NOP or idle) |

## Verification
The receive mode is driven with runs of good halves, single and repeated CRC failures, bubbles that arrive together with a failure, and bubbles in the fast mode. These patterns separate a correct exit condition from one that leaves on any bubble or ignores the failure. The transmit side gets one-NOP and two-NOP hints with dense slots, with sparse slots, and with new hints landing on a non-zero owed count. These show whether counts are dropped, summed or merged by maximum, and whether the reserved codes are ignored. A long randomised phase mixes all inputs. A queue of accepted payloads, compared on every cycle, catches any lost or reordered flit.

// File: rtl/flit_pkg.sv
// Package: shared types and helpers for the flit path controller.
// Assumes hint codes are 2 bits wide; 11 is reserved and requests nothing.
package flit_pkg;

    typedef enum logic [0:0] {
        MODE_FAST = 1'b0,
        MODE_FEC  = 1'b1
    } rx_mode_e;

    typedef logic [1:0] hint_code_t;

    localparam hint_code_t HINT_NONE = 2'b00;
    localparam hint_code_t HINT_ONE  = 2'b01;
    localparam hint_code_t HINT_TWO  = 2'b10;

    localparam int unsigned MAX_NOPS = 2;
    localparam int unsigned PEND_W   = $clog2(MAX_NOPS + 1);

    // Number of NOP flits a hint code requests.
    function automatic logic [PEND_W-1:0] hint_nops(input hint_code_t code);
        case (code)
            HINT_ONE: hint_nops = PEND_W'(1);
            HINT_TWO: hint_nops = PEND_W'(2);
            default:  hint_nops = '0;
        endcase
    endfunction

endpackage

// File: rtl/flit_rx_mode.sv
// Module: receive mode machine. It picks the fast or the corrected route for each
// half-flit and raises a one-cycle hint request when it falls into the corrected
// mode. Assumes at most one half-flit per cycle and that bubble and CRC status
// belong to the same cycle.
module flit_rx_mode
    import flit_pkg::*;
#(
    parameter hint_code_t HINT_REQ = HINT_TWO
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_vld,
    input  logic       crc_ok,
    input  logic       bubble,
    output logic       fast_rel,
    output logic       fec_rel,
    output logic       mode_fec,
    output logic       hint_vld,
    output hint_code_t hint_code
);

    rx_mode_e   mode_q;
    rx_mode_e   mode_d;
    logic       crc_fail;
    logic       enter_fec;

    assign crc_fail  = half_vld && !crc_ok;
    assign enter_fec = (mode_q == MODE_FAST) && crc_fail;

    // Next mode: fail moves to FEC; a clean bubble moves back to FAST.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FAST: if (crc_fail)            mode_d = MODE_FEC;
            MODE_FEC:  if (bubble && !crc_fail) mode_d = MODE_FAST;
            default:                            mode_d = MODE_FAST;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FAST;
        else        mode_q <= mode_d;
    end

    // Hint request register: one pulse per entry into FEC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hint_vld  <= 1'b0;
            hint_code <= HINT_NONE;
        end else begin
            hint_vld  <= enter_fec;
            hint_code <= enter_fec ? HINT_REQ : HINT_NONE;
        end
    end

    // Route selection for the half present this cycle.
    always_comb begin
        fast_rel = half_vld && crc_ok && (mode_q == MODE_FAST);
        fec_rel  = half_vld && !fast_rel;
    end

    assign mode_fec = (mode_q == MODE_FEC);

endmodule

// File: rtl/flit_nop_sched.sv
// Module: owed-NOP counter. It merges partner hints by maximum and spends one
// NOP per transmit slot. Assumes a hint lasts one cycle and counts for slots
// from the following cycle.
module flit_nop_sched
    import flit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              hint_vld,
    input  hint_code_t        hint_code,
    output logic              nop_owed,
    output logic [PEND_W-1:0] pend
);

    logic [PEND_W-1:0] remain;
    logic [PEND_W-1:0] req;
    logic [PEND_W-1:0] pend_d;

    assign nop_owed = (pend != '0);

    // Remaining count after this slot, requested count, and their maximum.
    always_comb begin
        remain = (slot && nop_owed) ? pend - PEND_W'(1) : pend;
        req    = hint_vld ? hint_nops(hint_code) : '0;
        pend_d = (req > remain) ? req : remain;
    end

    // Owed-count register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end

endmodule

// File: rtl/flit_tx_mux.sv
// Module: outgoing flit register. In each slot it sends a NOP when one is owed,
// or else the offered payload. Assumes one flit per slot and that the payload
// source holds its flit until ready.
module flit_tx_mux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              nop_owed,
    input  logic              pl_vld,
    input  logic [DATA_W-1:0] pl_data,
    output logic              pl_rdy,
    output logic              out_vld,
    output logic              out_nop,
    output logic [DATA_W-1:0] out_data
);

    logic take_pl;

    // Payload is taken only in a slot with no NOP owed.
    always_comb begin
        pl_rdy  = slot && !nop_owed;
        take_pl = pl_rdy && pl_vld;
    end

    // Output flit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_nop  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld  <= take_pl || (slot && nop_owed);
            out_nop  <= slot && nop_owed;
            out_data <= take_pl ? pl_data : '0;
        end
    end

endmodule

// File: rtl/flit_path_ctrl.sv
// Module: top of the flit latency-path controller. It ties the receive mode
// machine to the transmit NOP scheduler and the outgoing flit register.
// Assumes the CRC, bubble and hint inputs are synchronous to clk.
module flit_path_ctrl
    import flit_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter hint_code_t  HINT_REQ = HINT_TWO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_half_vld,
    input  logic              rx_crc_ok,
    input  logic              rx_bubble,
    output logic              rx_fast_rel,
    output logic              rx_fec_rel,
    output logic              path_fec,
    output logic              hint_tx_vld,
    output logic [1:0]        hint_tx_code,
    input  logic              hint_rx_vld,
    input  logic [1:0]        hint_rx_code,
    input  logic              tx_slot,
    input  logic              tx_pl_vld,
    input  logic [DATA_W-1:0] tx_pl_data,
    output logic              tx_pl_rdy,
    output logic              tx_out_vld,
    output logic              tx_out_nop,
    output logic [DATA_W-1:0] tx_out_data
);

    logic              nop_owed;
    logic [PEND_W-1:0] pend;
    hint_code_t        hint_code_int;

    flit_rx_mode #(.HINT_REQ(HINT_REQ)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_vld  (rx_half_vld),
        .crc_ok    (rx_crc_ok),
        .bubble    (rx_bubble),
        .fast_rel  (rx_fast_rel),
        .fec_rel   (rx_fec_rel),
        .mode_fec  (path_fec),
        .hint_vld  (hint_tx_vld),
        .hint_code (hint_code_int)
    );

    assign hint_tx_code = hint_code_int;

    flit_nop_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (tx_slot),
        .hint_vld  (hint_rx_vld),
        .hint_code (hint_rx_code),
        .nop_owed  (nop_owed),
        .pend      (pend)
    );

    flit_tx_mux #(.DATA_W(DATA_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (tx_slot),
        .nop_owed (nop_owed),
        .pl_vld   (tx_pl_vld),
        .pl_data  (tx_pl_data),
        .pl_rdy   (tx_pl_rdy),
        .out_vld  (tx_out_vld),
        .out_nop  (tx_out_nop),
        .out_data (tx_out_data)
    );

endmodule

// File: rtl/flit_path_ctrl_chk.sv
// Module: assertion checker bound to flit_path_ctrl. Relates mode, hint and
// transmit ports over time.
module flit_path_ctrl_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter logic [1:0]  HINT_REQ = 2'b10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_half_vld,
    input logic              rx_crc_ok,
    input logic              rx_bubble,
    input logic              rx_fast_rel,
    input logic              path_fec,
    input logic              hint_tx_vld,
    input logic [1:0]        hint_tx_code,
    input logic              tx_slot,
    input logic              tx_pl_rdy,
    input logic              tx_out_vld,
    input logic              tx_out_nop,
    input logic [DATA_W-1:0] tx_out_data
);

    p_fec_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_fec && rx_half_vld && !rx_crc_ok) |=> path_fec);

    p_fast_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fast_rel |-> (!path_fec && rx_crc_ok && rx_half_vld));

    p_bubble_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (path_fec && rx_bubble && !(rx_half_vld && !rx_crc_ok)) |=> !path_fec);

    p_stay_fec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (path_fec && !rx_bubble) |=> path_fec);

    p_hint_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hint_tx_vld |-> (path_fec && !$past(path_fec) && hint_tx_code == HINT_REQ));

    p_nop_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_nop |-> (tx_out_vld && tx_out_data == '0));

    p_rdy_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pl_rdy |-> tx_slot);

    p_out_needs_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_slot |=> !tx_out_vld);

endmodule

bind flit_path_ctrl flit_path_ctrl_chk #(.DATA_W(DATA_W), .HINT_REQ(HINT_REQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_half_vld  (rx_half_vld),
    .rx_crc_ok    (rx_crc_ok),
    .rx_bubble    (rx_bubble),
    .rx_fast_rel  (rx_fast_rel),
    .path_fec     (path_fec),
    .hint_tx_vld  (hint_tx_vld),
    .hint_tx_code (hint_tx_code),
    .tx_slot      (tx_slot),
    .tx_pl_rdy    (tx_pl_rdy),
    .tx_out_vld   (tx_out_vld),
    .tx_out_nop   (tx_out_nop),
    .tx_out_data  (tx_out_data)
);

// File: tb/flit_path_ctrl_bench.sv
// Bench: behavioural reference model compared with the design on every cycle.
module flit_path_ctrl_bench;

    localparam int         DW  = 32;
    localparam logic [1:0] REQ = 2'b10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rx_half_vld, rx_crc_ok, rx_bubble;
    logic          rx_fast_rel, rx_fec_rel, path_fec;
    logic          hint_tx_vld;
    logic [1:0]    hint_tx_code;
    logic          hint_rx_vld;
    logic [1:0]    hint_rx_code;
    logic          tx_slot, tx_pl_vld;
    logic [DW-1:0] tx_pl_data;
    logic          tx_pl_rdy, tx_out_vld, tx_out_nop;
    logic [DW-1:0] tx_out_data;

    always #5 clk = ~clk;

    flit_path_ctrl #(.DATA_W(DW), .HINT_REQ(REQ)) u_flit_path_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_half_vld(rx_half_vld), .rx_crc_ok(rx_crc_ok), .rx_bubble(rx_bubble),
        .rx_fast_rel(rx_fast_rel), .rx_fec_rel(rx_fec_rel), .path_fec(path_fec),
        .hint_tx_vld(hint_tx_vld), .hint_tx_code(hint_tx_code),
        .hint_rx_vld(hint_rx_vld), .hint_rx_code(hint_rx_code),
        .tx_slot(tx_slot), .tx_pl_vld(tx_pl_vld), .tx_pl_data(tx_pl_data),
        .tx_pl_rdy(tx_pl_rdy), .tx_out_vld(tx_out_vld), .tx_out_nop(tx_out_nop),
        .tx_out_data(tx_out_data)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference model state.
    bit          m_fec, m_hint, m_out_vld, m_out_nop, m_out_pl;
    int          m_owed;
    logic [DW-1:0] m_q[$];
    logic [DW-1:0] seq = 1;

    function automatic int nops_for(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b10) return 2;
        return 0;
    endfunction

    // Model update at each rising edge from the inputs held since the last falling edge.
    always @(posedge clk) begin
        bit fail_h;
        int remain, req;
        if (!rst_n) begin
            m_fec = 0; m_hint = 0; m_out_vld = 0; m_out_nop = 0; m_out_pl = 0;
            m_owed = 0; m_q.delete();
        end else begin
            fail_h    = rx_half_vld && !rx_crc_ok;
            m_hint    = !m_fec && fail_h;
            if (!m_fec && fail_h) m_fec = 1;
            else if (m_fec && rx_bubble && !fail_h) m_fec = 0;
            m_out_nop = tx_slot && (m_owed > 0);
            m_out_pl  = tx_slot && (m_owed == 0) && tx_pl_vld;
            m_out_vld = m_out_nop || m_out_pl;
            if (m_out_pl) m_q.push_back(tx_pl_data);
            remain = m_out_nop ? m_owed - 1 : m_owed;
            req    = hint_rx_vld ? nops_for(hint_rx_code) : 0;
            m_owed = (req > remain) ? req : remain;
        end
    end

    task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model.
    task automatic check_all();
        logic [DW-1:0] exp_data;
        bit exp_fast;
        exp_fast = rx_half_vld && rx_crc_ok && !m_fec;
        chk("R2 R4", "path_fec", DW'(path_fec), DW'(m_fec));
        chk("R3", "rx_fast_rel", DW'(rx_fast_rel), DW'(exp_fast));
        chk("R3", "rx_fec_rel", DW'(rx_fec_rel), DW'(rx_half_vld && !exp_fast));
        chk("R5", "hint_tx_vld", DW'(hint_tx_vld), DW'(m_hint));
        chk("R5", "hint_tx_code", DW'(hint_tx_code), m_hint ? DW'(REQ) : '0);
        chk("R8", "tx_pl_rdy", DW'(tx_pl_rdy), DW'(tx_slot && m_owed == 0));
        chk("R7 R10", "tx_out_vld", DW'(tx_out_vld), DW'(m_out_vld));
        chk("R6 R7 R9", "tx_out_nop", DW'(tx_out_nop), DW'(m_out_nop));
        exp_data = '0;
        if (m_out_pl && m_q.size() > 0) exp_data = m_q.pop_front();
        chk("R8", "tx_out_data", tx_out_data, exp_data);
    endtask

    // One cycle: apply inputs now (a falling edge), check at the next falling edge.
    task automatic cyc(input bit v, input bit ok, input bit bub, input bit hv,
                       input logic [1:0] hc, input bit sl, input bit pv);
        rx_half_vld = v; rx_crc_ok = ok; rx_bubble = bub;
        hint_rx_vld = hv; hint_rx_code = hc; tx_slot = sl; tx_pl_vld = pv;
        tx_pl_data = seq; seq = seq + 1;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        rst_n = 0;
        rx_half_vld = 0; rx_crc_ok = 0; rx_bubble = 0; hint_rx_vld = 0; hint_rx_code = 0;
        tx_slot = 0; tx_pl_vld = 0; tx_pl_data = 0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1", "path_fec", DW'(path_fec), '0);
        chk("R1", "hint_tx_vld", DW'(hint_tx_vld), '0);
        chk("R1", "tx_out_vld", DW'(tx_out_vld), '0);
        chk("R1", "tx_out_data", tx_out_data, '0);
        rst_n = 1;
        // R8: plain payload flow; R3 fast release.
        repeat (4) cyc(1, 1, 0, 0, 2'b00, 1, 1);
        // R4: bubble in fast mode has no effect.
        cyc(1, 1, 1, 0, 2'b00, 1, 1);
        // R2 R5: failure enters FEC with one hint.
        cyc(1, 0, 0, 0, 2'b00, 1, 1);
        // R5: repeated failures in FEC, no new hint; R3 good halves go to FEC route.
        cyc(1, 0, 0, 0, 2'b00, 1, 0);
        cyc(1, 1, 0, 0, 2'b00, 0, 1);
        // R4: bubble with failure keeps FEC, then clean bubble exits.
        cyc(1, 0, 1, 0, 2'b00, 1, 1);
        cyc(0, 0, 1, 0, 2'b00, 1, 1);
        cyc(1, 1, 0, 0, 2'b00, 1, 1);
        // R6 R7: one NOP, then two NOPs.
        cyc(0, 0, 0, 1, 2'b01, 1, 1);
        repeat (3) cyc(0, 0, 0, 0, 2'b00, 1, 1);
        cyc(0, 0, 0, 1, 2'b10, 1, 1);
        repeat (4) cyc(0, 0, 0, 0, 2'b00, 1, 1);
        // R6: codes 00 and 11 request nothing.
        cyc(0, 0, 0, 1, 2'b11, 1, 1);
        cyc(0, 0, 0, 1, 2'b00, 1, 1);
        repeat (2) cyc(0, 0, 0, 0, 2'b00, 1, 1);
        // R10: hint without slots keeps count until slots resume.
        cyc(0, 0, 0, 1, 2'b10, 0, 1);
        repeat (3) cyc(0, 0, 0, 0, 2'b00, 0, 1);
        repeat (4) cyc(0, 0, 0, 0, 2'b00, 1, 1);
        // R9: one-NOP hint on two owed keeps two; two-NOP hint on one owed gives two.
        cyc(0, 0, 0, 1, 2'b10, 0, 1);
        cyc(0, 0, 0, 1, 2'b01, 0, 1);
        cyc(0, 0, 0, 0, 2'b00, 1, 1);
        cyc(0, 0, 0, 1, 2'b10, 0, 1);
        repeat (5) cyc(0, 0, 0, 0, 2'b00, 1, 1);
        // Mixed random traffic across all requirements.
        for (int i = 0; i < 3000; i++)
            cyc($urandom % 2 == 0, $urandom % 8 != 0, $urandom % 6 == 0,
                $urandom % 10 == 0, 2'($urandom % 4), $urandom % 4 != 0, $urandom % 3 != 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule